// File: doc/BRIEF.md
# Banked Data Pointer Register File

This block keeps eight 16-bit data pointers for an 8051-compatible core and presents exactly one of them, the active pointer, as the external data memory address. A 3-bit select field decides which pointer is active. Every pointer operation acts only on the active entry:

- a full 16-bit immediate load
- a low-byte or high-byte write through the special-function register bus
- an increment

A single write to the select register re-targets all of these operations. There is no save or restore of pointer contents, and unselected pointers keep their values.

The core's decoder drives plain strobes: a 16-bit load with its data, an increment, and an SFR read or write with an 8-bit address and write data. Low-byte and high-byte writes to the active pointer arrive as SFR writes at the pointer byte addresses. The select register, the pointer output and the SFR read data are all registered. The active pointer output therefore follows an operation or a selection change by one clock.

Top module: `dptr_bank`

## Requirements
- R1: Each of the eight pointers (numbered 0 to 7) keeps its value while another pointer is selected or modified; with no load, increment or SFR write in a cycle, `dptr_o` is unchanged.
- R2: The select register sits at SFR address 0x92; an SFR write there sets the selection from bits 2..0 of the write data. Bits 7..3 are ignored, and a read of 0x92 returns the selection in bits 2..0 with bits 7..3 as 0.
- R3: A cycle with `ld16_i` high stores `ld_data_i` into the active pointer, and `dptr_o` shows it from the next cycle.
- R4: An SFR write at 0x82 replaces bits 7..0 of the active pointer, and an SFR write at 0x83 replaces bits 15..8; the other byte is kept.
- R5: `inc_i` adds one to the active pointer, wrapping from 0xFFFF to 0x0000 with no other effect.
- R6: `dptr_o` always presents the active pointer, one cycle after the clock edge at which the pointer or the selection changed; after a select write it shows the newly selected pointer's stored value.
- R7: When a select write and a pointer operation fall in the same cycle, the operation applies to the previously selected pointer, and the new selection takes effect from the next cycle.
- R8: When several pointer operations coincide, the 16-bit load wins over a byte write, which wins over an increment; the losing operations have no effect.
- R9: An SFR read gives `sfr_rvalid_o` high and the data on `sfr_rdata_o` in the next cycle. Address 0x82 returns the active pointer's low byte, 0x83 its high byte and 0x92 the selection. Any other address leaves `sfr_rvalid_o` low with `sfr_rdata_o` at 0, and `sfr_rdata_o` is 0 whenever `sfr_rvalid_o` is low. The value returned is the state before any update made in the read cycle.
- R10: Synchronous active-high reset clears all eight pointers and the selection, so pointer 0 is active, `dptr_o` is 0 and `sfr_rvalid_o` is 0 in the cycle after reset is sampled.
- R11: An SFR write to any address other than 0x82, 0x83 and 0x92 changes no pointer and no selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld16_i | input | 1 | Load the active pointer with `ld_data_i` |
| ld_data_i | input | 16 | Immediate pointer value |
| inc_i | input | 1 | Increment the active pointer |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_rd_i | input | 1 | SFR read strobe |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | Registered SFR read data |
| sfr_rvalid_o | output | 1 | SFR read hit one of the block's addresses, one cycle after the strobe |
| dptr_o | output | 16 | Registered active pointer value |

## Verification
A wrongly stored entry stays hidden until its pointer is selected. The bench therefore loads a distinct value into every pointer and then selects each one in turn: a corrupt entry, or a write that leaked into a neighbour, appears on `dptr_o` exactly one cycle after that select write. A wrong select register shows up as a wrong pointer on `dptr_o` in the cycle after the select write, and as a wrong value on a read of 0x92 one cycle after the read strobe. A wrong update path, such as a byte written to the wrong half, a missed wrap, a broken priority or an operation sent to the new selection, shows on `dptr_o` in the very next cycle.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  // Resolved operation on the active pointer for one cycle
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_WR_LO = 3'd2,
    OP_WR_HI = 3'd3,
    OP_INC   = 3'd4
  } ptr_op_e;

endpackage

// File: rtl/dptr_op_dec.sv
module dptr_op_dec
  import dptr_pkg::*;
#(
  parameter int AW       = 8,
  parameter int ADDR_DPL = 8'h82,
  parameter int ADDR_DPH = 8'h83,
  parameter int ADDR_SEL = 8'h92
) (
  input  logic          ld16_i,
  input  logic          inc_i,
  input  logic          sfr_wr_i,
  input  logic [AW-1:0] sfr_addr_i,
  output ptr_op_e       op_o,
  output logic          sel_we_o
);

  logic hit_lo;
  logic hit_hi;

  assign hit_lo   = sfr_wr_i && (sfr_addr_i == AW'(ADDR_DPL));
  assign hit_hi   = sfr_wr_i && (sfr_addr_i == AW'(ADDR_DPH));
  assign sel_we_o = sfr_wr_i && (sfr_addr_i == AW'(ADDR_SEL));

  // Fixed priority: full load, then byte write, then increment
  always_comb begin
    op_o = OP_NONE;
    if (ld16_i)      op_o = OP_LOAD;
    else if (hit_lo) op_o = OP_WR_LO;
    else if (hit_hi) op_o = OP_WR_HI;
    else if (inc_i)  op_o = OP_INC;
  end

endmodule

// File: rtl/dptr_sel_reg.sv
module dptr_sel_reg #(
  parameter int DW   = 8,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [SELW-1:0] sel_q_o,
  output logic [SELW-1:0] sel_nxt_o
);

  logic [SELW-1:0] sel_q;

  // Upper data bits are dropped here, so they can never be stored
  assign sel_nxt_o = we_i ? wdata_i[SELW-1:0] : sel_q;
  assign sel_q_o   = sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_nxt_o;
  end

endmodule

// File: rtl/dptr_file.sv
module dptr_file
  import dptr_pkg::*;
#(
  parameter int NPTR = 8,
  parameter int DW   = 8,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  ptr_op_e         op_i,
  input  logic [SELW-1:0] sel_cur_i,
  input  logic [SELW-1:0] sel_nxt_i,
  input  logic [2*DW-1:0] ld_data_i,
  input  logic [DW-1:0]   byte_i,
  output logic [2*DW-1:0] cur_o,
  output logic [2*DW-1:0] dptr_o
);

  localparam int PW = 2 * DW;

  logic [PW-1:0] ent [NPTR];
  logic [PW-1:0] upd;
  logic [PW-1:0] dptr_q;
  logic          busy;

  assign cur_o  = ent[sel_cur_i];
  assign busy   = (op_i != OP_NONE);
  assign dptr_o = dptr_q;

  always_comb begin
    case (op_i)
      OP_LOAD:  upd = ld_data_i;
      OP_WR_LO: upd = {cur_o[PW-1:DW], byte_i};
      OP_WR_HI: upd = {byte_i, cur_o[DW-1:0]};
      OP_INC:   upd = cur_o + PW'(1);
      default:  upd = cur_o;
    endcase
  end

  // One register per pointer, each with its own write enable
  for (genvar g = 0; g < NPTR; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        ent[g] <= '0;
      else if (busy && (sel_cur_i == SELW'(g)))
        ent[g] <= upd;
    end
  end

  // Output register tracks the entry that will be active after this edge
  always_ff @(posedge clk) begin
    if (rst)
      dptr_q <= '0;
    else if (busy && (sel_nxt_i == sel_cur_i))
      dptr_q <= upd;
    else
      dptr_q <= ent[sel_nxt_i];
  end

endmodule

// File: rtl/dptr_sfr_rd.sv
module dptr_sfr_rd #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int SELW     = 3,
  parameter int ADDR_DPL = 8'h82,
  parameter int ADDR_DPH = 8'h83,
  parameter int ADDR_SEL = 8'h92
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [2*DW-1:0] cur_i,
  input  logic [SELW-1:0] sel_i,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      if (rd_i) begin
        if (addr_i == AW'(ADDR_DPL)) begin
          rdata_o  <= cur_i[DW-1:0];
          rvalid_o <= 1'b1;
        end else if (addr_i == AW'(ADDR_DPH)) begin
          rdata_o  <= cur_i[2*DW-1:DW];
          rvalid_o <= 1'b1;
        end else if (addr_i == AW'(ADDR_SEL)) begin
          rdata_o  <= {{(DW-SELW){1'b0}}, sel_i};
          rvalid_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
  import dptr_pkg::*;
#(
  parameter int NPTR     = 8,
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int ADDR_DPL = 8'h82,
  parameter int ADDR_DPH = 8'h83,
  parameter int ADDR_SEL = 8'h92
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld16_i,
  input  logic [2*DW-1:0] ld_data_i,
  input  logic            inc_i,
  input  logic            sfr_wr_i,
  input  logic            sfr_rd_i,
  input  logic [AW-1:0]   sfr_addr_i,
  input  logic [DW-1:0]   sfr_wdata_i,
  output logic [DW-1:0]   sfr_rdata_o,
  output logic            sfr_rvalid_o,
  output logic [2*DW-1:0] dptr_o
);

  localparam int SELW = $clog2(NPTR);
  localparam int PW   = 2 * DW;

  ptr_op_e         op;
  logic            sel_we;
  logic [SELW-1:0] sel_q;
  logic [SELW-1:0] sel_nxt;
  logic [PW-1:0]   cur;

  dptr_op_dec #(
    .AW(AW), .ADDR_DPL(ADDR_DPL), .ADDR_DPH(ADDR_DPH), .ADDR_SEL(ADDR_SEL)
  ) u_dec (
    .ld16_i     (ld16_i),
    .inc_i      (inc_i),
    .sfr_wr_i   (sfr_wr_i),
    .sfr_addr_i (sfr_addr_i),
    .op_o       (op),
    .sel_we_o   (sel_we)
  );

  dptr_sel_reg #(.DW(DW), .SELW(SELW)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .we_i      (sel_we),
    .wdata_i   (sfr_wdata_i),
    .sel_q_o   (sel_q),
    .sel_nxt_o (sel_nxt)
  );

  dptr_file #(.NPTR(NPTR), .DW(DW), .SELW(SELW)) u_file (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .sel_cur_i (sel_q),
    .sel_nxt_i (sel_nxt),
    .ld_data_i (ld_data_i),
    .byte_i    (sfr_wdata_i),
    .cur_o     (cur),
    .dptr_o    (dptr_o)
  );

  dptr_sfr_rd #(
    .AW(AW), .DW(DW), .SELW(SELW),
    .ADDR_DPL(ADDR_DPL), .ADDR_DPH(ADDR_DPH), .ADDR_SEL(ADDR_SEL)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (sfr_rd_i),
    .addr_i   (sfr_addr_i),
    .cur_i    (cur),
    .sel_i    (sel_q),
    .rdata_o  (sfr_rdata_o),
    .rvalid_o (sfr_rvalid_o)
  );

endmodule

// File: rtl/dptr_bank_chk.sv
module dptr_bank_chk #(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int ADDR_DPL = 8'h82,
  parameter int ADDR_DPH = 8'h83,
  parameter int ADDR_SEL = 8'h92
) (
  input logic            clk,
  input logic            rst,
  input logic            ld16_i,
  input logic [2*DW-1:0] ld_data_i,
  input logic            inc_i,
  input logic            sfr_wr_i,
  input logic            sfr_rd_i,
  input logic [AW-1:0]   sfr_addr_i,
  input logic [DW-1:0]   sfr_wdata_i,
  input logic [DW-1:0]   sfr_rdata_o,
  input logic            sfr_rvalid_o,
  input logic [2*DW-1:0] dptr_o
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  logic wr_lo, wr_hi, wr_sel, wr_other, rd_hit;
  assign wr_lo    = sfr_wr_i && (sfr_addr_i == AW'(ADDR_DPL));
  assign wr_hi    = sfr_wr_i && (sfr_addr_i == AW'(ADDR_DPH));
  assign wr_sel   = sfr_wr_i && (sfr_addr_i == AW'(ADDR_SEL));
  assign wr_other = sfr_wr_i && !wr_lo && !wr_hi && !wr_sel;
  assign rd_hit   = sfr_rd_i && ((sfr_addr_i == AW'(ADDR_DPL)) ||
                    (sfr_addr_i == AW'(ADDR_DPH)) || (sfr_addr_i == AW'(ADDR_SEL)));

  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> (dptr_o == '0) && !sfr_rvalid_o);

  // R3 R8
  load_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (ld16_i && !wr_sel) |=> dptr_o == $past(ld_data_i));

  // R4
  byte_lo_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (wr_lo && !ld16_i) |=> (dptr_o[DW-1:0] == $past(sfr_wdata_i)) &&
                           (dptr_o[2*DW-1:DW] == $past(dptr_o[2*DW-1:DW])));

  // R5
  inc_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (inc_i && !ld16_i && !sfr_wr_i) |=> dptr_o == $past(dptr_o) + (2*DW)'(1));

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (!ld16_i && !inc_i && !sfr_wr_i) |=> $stable(dptr_o));

  // R11
  ignore_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (wr_other && !ld16_i && !inc_i) |=> $stable(dptr_o));

  // R2
  sel_rd_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (sfr_rd_i && (sfr_addr_i == AW'(ADDR_SEL))) |=> sfr_rdata_o[DW-1:3] == '0);

  // R9
  rvalid_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    rd_hit |=> sfr_rvalid_o);

  // R9
  rquiet_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !rd_hit |=> !sfr_rvalid_o && (sfr_rdata_o == '0));

endmodule

bind dptr_bank dptr_bank_chk #(
  .DW(DW), .AW(AW), .ADDR_DPL(ADDR_DPL), .ADDR_DPH(ADDR_DPH), .ADDR_SEL(ADDR_SEL)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ld16_i       (ld16_i),
  .ld_data_i    (ld_data_i),
  .inc_i        (inc_i),
  .sfr_wr_i     (sfr_wr_i),
  .sfr_rd_i     (sfr_rd_i),
  .sfr_addr_i   (sfr_addr_i),
  .sfr_wdata_i  (sfr_wdata_i),
  .sfr_rdata_o  (sfr_rdata_o),
  .sfr_rvalid_o (sfr_rvalid_o),
  .dptr_o       (dptr_o)
);

// File: tb/dptr_bank_bench.sv
module dptr_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld16_i = 1'b0;
  logic [15:0] ld_data_i = '0;
  logic        inc_i = 1'b0;
  logic        sfr_wr_i = 1'b0;
  logic        sfr_rd_i = 1'b0;
  logic [7:0]  sfr_addr_i = '0;
  logic [7:0]  sfr_wdata_i = '0;
  logic [7:0]  sfr_rdata_o;
  logic        sfr_rvalid_o;
  logic [15:0] dptr_o;

  always #4 clk = ~clk;

  dptr_bank u_dptr_bank (
    .clk(clk), .rst(rst), .ld16_i(ld16_i), .ld_data_i(ld_data_i), .inc_i(inc_i),
    .sfr_wr_i(sfr_wr_i), .sfr_rd_i(sfr_rd_i), .sfr_addr_i(sfr_addr_i),
    .sfr_wdata_i(sfr_wdata_i), .sfr_rdata_o(sfr_rdata_o),
    .sfr_rvalid_o(sfr_rvalid_o), .dptr_o(dptr_o)
  );

  typedef struct {
    logic [15:0] ptr;
    logic        rv;
    logic [7:0]  rd;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [15:0] m [8];
  int          s = 0;

  // Driver: apply one cycle of stimulus, advance the model, queue the expectation
  task automatic step(input bit r, input bit ld, input logic [15:0] ldv, input bit inc,
                      input bit wr, input bit rd, input logic [7:0] a,
                      input logic [7:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; ld16_i = ld; ld_data_i = ldv; inc_i = inc;
    sfr_wr_i = wr; sfr_rd_i = rd; sfr_addr_i = a; sfr_wdata_i = wd;
    e.rv = 1'b0; e.rd = 8'h00; e.tag = tag;
    if (rd && !r) begin
      if (a == 8'h82)      begin e.rv = 1'b1; e.rd = m[s][7:0];  end
      else if (a == 8'h83) begin e.rv = 1'b1; e.rd = m[s][15:8]; end
      else if (a == 8'h92) begin e.rv = 1'b1; e.rd = 8'(s);      end
    end
    if (r) begin
      for (int i = 0; i < 8; i++) m[i] = '0;
      s = 0;
    end else begin
      if (ld)                     m[s] = ldv;
      else if (wr && a == 8'h82)  m[s][7:0] = wd;
      else if (wr && a == 8'h83)  m[s][15:8] = wd;
      else if (inc)               m[s] = m[s] + 16'd1;
      if (wr && a == 8'h92) s = int'(wd[2:0]);
    end
    e.ptr = m[s];
    sb.push_back(e);
  endtask

  task automatic idle(input string t);             step(0,0,0,0,0,0,0,0,t);    endtask
  task automatic load(input logic [15:0] v, input string t); step(0,1,v,0,0,0,0,0,t); endtask
  task automatic wsfr(input logic [7:0] a, input logic [7:0] d, input string t);
    step(0,0,0,0,1,0,a,d,t);
  endtask
  task automatic rsfr(input logic [7:0] a, input string t); step(0,0,0,0,0,1,a,0,t); endtask
  task automatic incr(input string t);             step(0,0,0,1,0,0,0,0,t);    endtask

  // Monitor: compare one queued expectation per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (dptr_o !== e.ptr || sfr_rvalid_o !== e.rv || sfr_rdata_o !== e.rd) begin
          errors++;
          $display("FAIL %s: dptr=%h rv=%b rd=%h expected dptr=%h rv=%b rd=%h",
                   e.tag, dptr_o, sfr_rvalid_o, sfr_rdata_o, e.ptr, e.rv, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    step(1,0,0,0,0,0,0,0,"R10 reset");
    step(1,0,0,0,0,0,0,0,"R10 reset");
    idle("R10 after reset");
    rsfr(8'h92, "R10 R2 select reads 0");
    rsfr(8'h83, "R10 R9 high byte 0");
    load(16'h1FFF, "R3 load ptr0");
    rsfr(8'h82, "R9 low byte");
    rsfr(8'h83, "R9 high byte");
    wsfr(8'h92, 8'h06, "R2 R6 select 6");
    load(16'h2FA0, "R3 load ptr6");
    rsfr(8'h92, "R2 read select 6");
    wsfr(8'h92, 8'hF9, "R2 upper bits ignored");
    rsfr(8'h92, "R2 upper bits read 0");
    wsfr(8'h82, 8'h34, "R4 low byte");
    wsfr(8'h83, 8'h12, "R4 high byte");
    wsfr(8'h82, 8'hCD, "R4 low keeps high");
    wsfr(8'h92, 8'h00, "R1 R6 back to ptr0");
    wsfr(8'h92, 8'h06, "R1 R6 ptr6 kept");
    for (int k = 0; k < 8; k++) begin
      wsfr(8'h92, 8'(k), "R6 select k");
      load(16'(k * 16'h1111 + 16'h0101), "R3 fill k");
    end
    for (int k = 7; k >= 0; k--) begin
      wsfr(8'h92, 8'(k), "R1 ptr k intact");
      idle("R1 hold");
    end
    load(16'hFFFE, "R3 near top");
    incr("R5 inc");
    incr("R5 wrap");
    incr("R5 after wrap");
    step(0,1,16'hABCD,0,1,0,8'h92,8'h03,"R7 load uses old select");
    wsfr(8'h92, 8'h00, "R7 old ptr got load");
    step(0,1,16'h5A5A,1,0,0,0,0,"R8 load beats inc");
    step(0,0,0,1,1,0,8'h83,8'hEE,"R8 byte beats inc");
    step(0,0,0,1,1,0,8'h92,8'h02,"R7 inc uses old select");
    wsfr(8'h92, 8'h00, "R7 old ptr incremented");
    step(0,1,16'h7777,0,0,1,8'h82,0,"R9 read sees old value");
    rsfr(8'h82, "R9 read new value");
    rsfr(8'h90, "R9 foreign read");
    wsfr(8'h81, 8'hAA, "R11 foreign write");
    rsfr(8'h83, "R11 pointer unchanged");
    rsfr(8'h92, "R11 select unchanged");
    wsfr(8'h92, 8'h05, "R6 select 5");
    step(1,0,0,0,0,0,0,0,"R10 reset mid-run");
    rsfr(8'h92, "R10 select cleared");
    wsfr(8'h92, 8'h05, "R10 ptr5 cleared");
    idle("R1 idle");
    idle("R1 idle");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule